// File: doc/BRIEF.md
# Interrupt Acceptance Unit

This unit sits next to the sequencer of an 8-bit processor core. At every instruction boundary it decides whether an interrupt is taken and, when one is, where execution continues. It keeps a falling-edge latch for the non-maskable pin and the pair of enable flip-flops (IFF1, IFF2). It holds the interrupt mode, honours the one-instruction grace period after an enable, and forms the destination from the mode, the I register and the byte a device returns during acknowledge.

The sequencer pulses `insn_end` in the last cycle of each instruction. A non-maskable request is answered one cycle later with `take_o` and a fixed destination. A maskable request first raises `ack_o` for exactly one cycle, during which the device drives `ack_data`. One cycle after that, the unit pulses `take_o` with the destination, or pulses `bad_o` when the byte cannot be used. All pins are plain control and status signals. Every output is a single-cycle pulse or a level, and there is no back-pressure: the sequencer must act on `take_o` in the cycle it appears. Stacking the program counter, instruction decode and bus timing belong to the sequencer.

Top module: `irq_accept`

## Requirements
- R1: A high-to-low change on `nmi_n` latches a pending non-maskable request. A boundary that sees it pending pulses `take_o` in the next cycle with `vec_o` = 0x0066 and `vec_tbl_o` = 0. Holding `nmi_n` low does not latch a second request.
- R2: When a non-maskable request is pending at a boundary, it is taken even if the maskable line is active, and no `ack_o` follows.
- R3: The maskable line `int_n` is level-sensitive and active low, with no latch. A low pulse that ends before a boundary causes nothing.
- R4: `iff_o[0]` is IFF1 and `iff_o[1]` is IFF2. An enable strobe sets both. A disable strobe clears both in the next cycle. Reset clears both.
- R5: A maskable request is refused at the boundary that coincides with an enable strobe, or at the first boundary after one. It is accepted from the following boundary on, provided IFF1 is set.
- R6: Accepting a maskable request clears IFF1 and IFF2 and raises `ack_o` in the cycle after the boundary. The result (`take_o` or `bad_o`) appears in the cycle after `ack_o`.
- R7: Taking a non-maskable request copies IFF1 into IFF2 and clears IFF1. The return strobe `nmi_ret_stb` copies IFF2 back into IFF1.
- R8: In mode 0, a byte of the form 11ttt111 gives `vec_o` = ttt×8 (0x0000 to 0x0038) with `vec_tbl_o` = 0.
- R9: In mode 0, any other byte pulses `bad_o` instead of `take_o`.
- R10: In mode 1, the byte is ignored and `vec_o` = 0x0038 with `vec_tbl_o` = 0.
- R11: In mode 2, `vec_o` = {I register, byte with bit 0 forced to 0} and `vec_tbl_o` = 1.
- R12: `mode_sel` codes are 0, 1 and 2 for the three modes and take effect on `mode_wr`. Code 3 is ignored. Reset selects mode 0.
- R13: Boundaries that arrive during the acknowledge cycle are ignored. A non-maskable edge seen then stays pending for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request pin, falling-edge sensitive |
| int_n | input | 1 | Maskable request line, active low |
| insn_end | input | 1 | Instruction boundary pulse from the sequencer |
| ei_stb | input | 1 | Enable-interrupts strobe |
| di_stb | input | 1 | Disable-interrupts strobe |
| nmi_ret_stb | input | 1 | Return-from-non-maskable strobe |
| mode_wr | input | 1 | Load `mode_sel` into the mode register |
| mode_sel | input | 2 | Requested mode code |
| ireg | input | DATA_W | I register contents |
| ack_data | input | DATA_W | Byte driven by the device while `ack_o` is high |
| take_o | output | 1 | One-cycle pulse: jump to `vec_o` |
| vec_o | output | ADDR_W | Destination address, or table address in mode 2 |
| vec_tbl_o | output | 1 | `vec_o` is a table entry address rather than code |
| ack_o | output | 1 | Acknowledge cycle of a maskable request |
| bad_o | output | 1 | One-cycle pulse: mode 0 byte was not a restart opcode |
| iff_o | output | 2 | Bit 0 IFF1, bit 1 IFF2 |

## Verification
The in-line assertions watch, on every cycle, that the non-maskable latch sets only on a falling edge and takes priority at a boundary. They also check that each acknowledge resolves to exactly one of take or reject, that the enable strobes move IFF1/IFF2 as specified, that a boundary during an enable strobe or an acknowledge raises no acknowledge, and that mode 1 and mode 2 addresses have their fixed form. Only the bench's scenarios show the actual destinations for given device bytes and I values, that a brief low pulse on the maskable line is lost, that a held-low non-maskable pin does not fire twice, that the ignored mode code leaves the mode unchanged, and that a request deferred by an acknowledge is taken later.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [1:0] {
    IMODE_ZERO = 2'd0,
    IMODE_ONE  = 2'd1,
    IMODE_TWO  = 2'd2,
    IMODE_RSVD = 2'd3
  } imode_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_ACK  = 1'b1
  } phase_e;

  // restart opcode layout: two ones, 3-bit target field, three ones
  localparam int RST_FIELD_LO = 3;
  localparam int RST_FIELD_W  = 3;

  function automatic logic is_rst_opcode(input logic [7:0] b);
    return (b[7:6] == 2'b11) && (b[2:0] == 3'b111);
  endfunction

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic taken,
  output logic pending
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~pin_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      prev_q <= pin_n;
      if (fall)
        pending <= 1'b1;
      else if (taken)
        pending <= 1'b0;
    end
  end

  // R1: a request only appears after the pin went from high to low
  p_edge_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> $past(prev_q && !pin_n));

endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ei,
  input  logic di,
  input  logic nmi_ret,
  input  logic boundary,
  input  logic nmi_acc,
  input  logic int_acc,
  output logic iff1,
  output logic iff2,
  output logic ei_window
);
  logic s1, s2;
  logic n1, n2;

  // strobes first, then the effect of an acceptance at this boundary
  always_comb begin
    s1 = iff1;
    s2 = iff2;
    if (di) begin
      s1 = 1'b0;
      s2 = 1'b0;
    end else if (ei) begin
      s1 = 1'b1;
      s2 = 1'b1;
    end else if (nmi_ret) begin
      s1 = iff2;
    end
    n1 = s1;
    n2 = s2;
    if (nmi_acc) begin
      n2 = s1;
      n1 = 1'b0;
    end else if (int_acc) begin
      n1 = 1'b0;
      n2 = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iff1      <= 1'b0;
      iff2      <= 1'b0;
      ei_window <= 1'b0;
    end else begin
      iff1 <= n1;
      iff2 <= n2;
      if (di || boundary)
        ei_window <= 1'b0;
      else if (ei)
        ei_window <= 1'b1;
    end
  end

  // R4: disable empties both flip-flops
  p_di_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    di |=> (!iff1 && !iff2));

  // R4: enable fills both unless an acceptance happens at the same time
  p_ei_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ei && !di && !nmi_acc && !int_acc) |=> (iff1 && iff2));

  // R7: non-maskable acceptance saves IFF1 in IFF2
  p_nmi_save_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_acc && !di && !ei && !nmi_ret) |=> (!iff1 && (iff2 == $past(iff1))));

  // R7: return restores IFF1 from IFF2
  p_ret_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_ret && !di && !ei && !nmi_acc && !int_acc) |=> (iff1 == $past(iff2)));

endmodule

// File: rtl/irq_vector_former.sv
module irq_vector_former
  import irq_accept_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 8,
  parameter logic [ADDR_W-1:0] FIXED_VECTOR = 16'h0038
) (
  input  imode_e            mode,
  input  logic [DATA_W-1:0] ireg,
  input  logic [DATA_W-1:0] dev_byte,
  output logic [ADDR_W-1:0] vec,
  output logic              tbl,
  output logic              ok
);
  localparam int TBL_W = 2 * DATA_W;
  localparam int RST_SH = RST_FIELD_W; // target field times eight

  logic [TBL_W-1:0]  tbl_addr;
  logic [ADDR_W-1:0] rst_addr;

  assign tbl_addr = {ireg, dev_byte[DATA_W-1:1], 1'b0};
  assign rst_addr = ADDR_W'({dev_byte[RST_FIELD_LO +: RST_FIELD_W], {RST_SH{1'b0}}});

  always_comb begin
    vec = FIXED_VECTOR;
    tbl = 1'b0;
    ok  = 1'b1;
    unique case (mode)
      IMODE_ZERO: begin
        ok  = is_rst_opcode(dev_byte[7:0]);
        vec = rst_addr;
      end
      IMODE_TWO: begin
        vec = ADDR_W'(tbl_addr);
        tbl = 1'b1;
      end
      default: begin
        vec = FIXED_VECTOR;
      end
    endcase
  end

endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] NMI_VECTOR   = 16'h0066,
  parameter logic [ADDR_W-1:0] FIXED_VECTOR = 16'h0038
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic              int_n,
  input  logic              insn_end,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              nmi_ret_stb,
  input  logic              mode_wr,
  input  logic [1:0]        mode_sel,
  input  logic [DATA_W-1:0] ireg,
  input  logic [DATA_W-1:0] ack_data,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              vec_tbl_o,
  output logic              ack_o,
  output logic              bad_o,
  output logic [1:0]        iff_o
);
  phase_e phase_q;
  imode_e mode_q;
  logic   busy;
  logic   nmi_pend;
  logic   iff1, iff2, ei_window;
  logic   nmi_acc, int_acc;
  logic [ADDR_W-1:0] fv_vec;
  logic   fv_tbl, fv_ok;

  assign busy  = (phase_q == PH_ACK);
  assign ack_o = busy;
  assign iff_o = {iff2, iff1};

  assign nmi_acc = insn_end && !busy && nmi_pend;
  assign int_acc = insn_end && !busy && !nmi_pend && !int_n &&
                   iff1 && !ei_window && !ei_stb && !di_stb;

  irq_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_n   (nmi_n),
    .taken   (nmi_acc),
    .pending (nmi_pend)
  );

  irq_enable_ctrl u_en (
    .clk       (clk),
    .rst_n     (rst_n),
    .ei        (ei_stb),
    .di        (di_stb),
    .nmi_ret   (nmi_ret_stb),
    .boundary  (insn_end),
    .nmi_acc   (nmi_acc),
    .int_acc   (int_acc),
    .iff1      (iff1),
    .iff2      (iff2),
    .ei_window (ei_window)
  );

  irq_vector_former #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .FIXED_VECTOR (FIXED_VECTOR)
  ) u_vec (
    .mode     (mode_q),
    .ireg     (ireg),
    .dev_byte (ack_data),
    .vec      (fv_vec),
    .tbl      (fv_tbl),
    .ok       (fv_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      mode_q    <= IMODE_ZERO;
      take_o    <= 1'b0;
      bad_o     <= 1'b0;
      vec_o     <= '0;
      vec_tbl_o <= 1'b0;
    end else begin
      take_o <= 1'b0;
      bad_o  <= 1'b0;
      if (mode_wr && (mode_sel != IMODE_RSVD))
        mode_q <= imode_e'(mode_sel);
      unique case (phase_q)
        PH_IDLE: begin
          if (nmi_acc) begin
            take_o    <= 1'b1;
            vec_o     <= NMI_VECTOR;
            vec_tbl_o <= 1'b0;
          end else if (int_acc) begin
            phase_q <= PH_ACK;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          if (fv_ok) begin
            take_o    <= 1'b1;
            vec_o     <= fv_vec;
            vec_tbl_o <= fv_tbl;
          end else begin
            bad_o <= 1'b1;
          end
        end
      endcase
    end
  end

  // R2: a pending non-maskable request wins the boundary
  p_nmi_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end && !busy && nmi_pend) |=> (take_o && (vec_o == NMI_VECTOR) && !ack_o));

  // R6: every acknowledge resolves to exactly one outcome
  p_ack_resolves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (take_o != bad_o));

  // R5: no acknowledge for a boundary that coincides with an enable
  p_ei_grace_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end && ei_stb && !busy && !nmi_pend) |=> !ack_o);

  // R13: boundaries during acknowledge start nothing new
  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && insn_end) |=> !ack_o);

  // R10: mode 1 always lands on the fixed address
  p_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && (mode_q == IMODE_ONE)) |=> (take_o && (vec_o == FIXED_VECTOR) && !vec_tbl_o));

  // R11: table addresses are even
  p_table_even_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_tbl_o) |-> !vec_o[0]);

endmodule

// File: tb/irq_accept_tb_top.sv
`timescale 1ns/1ps
module irq_accept_tb_top;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  typedef struct {
    int          cyc;
    int          kind;   // 0 take, 1 reject, 2 acknowledge
    logic [15:0] vec;
    logic        tbl;
    string       req;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_n = 1'b1, int_n = 1'b1, insn_end = 1'b0;
  logic ei_stb = 1'b0, di_stb = 1'b0, nmi_ret_stb = 1'b0, mode_wr = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [DATA_W-1:0] ireg = '0, ack_data = '0;
  logic take_o, vec_tbl_o, ack_o, bad_o;
  logic [ADDR_W-1:0] vec_o;
  logic [1:0] iff_o;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R0";
  ev_t exp_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_accept #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n),
    .insn_end(insn_end), .ei_stb(ei_stb), .di_stb(di_stb),
    .nmi_ret_stb(nmi_ret_stb), .mode_wr(mode_wr), .mode_sel(mode_sel),
    .ireg(ireg), .ack_data(ack_data), .take_o(take_o), .vec_o(vec_o),
    .vec_tbl_o(vec_tbl_o), .ack_o(ack_o), .bad_o(bad_o), .iff_o(iff_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse(input logic b, input logic en, input logic dis,
                       input logic ret, input logic mwr, input logic [1:0] mv);
    insn_end = b; ei_stb = en; di_stb = dis; nmi_ret_stb = ret;
    mode_wr = mwr; mode_sel = mv;
    tick();
    insn_end = 0; ei_stb = 0; di_stb = 0; nmi_ret_stb = 0; mode_wr = 0;
  endtask

  task automatic expect_ev(input int dc, input int kind, input logic [15:0] v,
                           input logic t, input string req);
    ev_t e;
    e.cyc = cyc + dc; e.kind = kind; e.vec = v; e.tbl = t; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic observe(input int kind);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      failures++;
      $display("FAIL %s unexpected event actual kind=%0d at cycle %0d expected none",
               cur_req, kind, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.cyc != cyc ||
          (kind == 0 && (e.vec != vec_o || e.tbl != vec_tbl_o))) begin
        failures++;
        $display("FAIL %s actual kind=%0d cyc=%0d vec=0x%0h tbl=%0b expected kind=%0d cyc=%0d vec=0x%0h tbl=%0b",
                 e.req, kind, cyc, vec_o, vec_tbl_o, e.kind, e.cyc, e.vec, e.tbl);
      end
    end
  endtask

  // monitor: compares produced events with the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ack_o)  observe(2);
      if (take_o) observe(0);
      if (bad_o)  observe(1);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();

    // reset state, R4 and R12 (mode 0 used below without a write)
    cur_req = "R4";
    chk(iff_o == 2'b00, "R4 reset iff", iff_o, 0);
    chk({take_o, ack_o, bad_o} == 3'b000, "R4 reset outputs", {take_o, ack_o, bad_o}, 0);

    // R5: boundary with the enable is refused; R8/R6 next boundary in mode 0
    cur_req = "R5";
    int_n = 0; ack_data = 8'hD7;
    pulse(1, 1, 0, 0, 0, 0);
    chk(iff_o == 2'b11, "R4 enable sets both", iff_o, 3);
    cur_req = "R8";
    expect_ev(1, 2, 0, 0, "R6");
    expect_ev(2, 0, 16'h0010, 0, "R8");
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();
    chk(iff_o == 2'b00, "R6 acceptance clears both", iff_o, 0);

    // R5 enable alone, next boundary refused; R9 bad restart byte
    cur_req = "R5";
    pulse(0, 1, 0, 0, 0, 0);
    pulse(1, 0, 0, 0, 0, 0);
    tick();
    cur_req = "R9";
    ack_data = 8'hCB;
    expect_ev(1, 2, 0, 0, "R6");
    expect_ev(2, 1, 0, 0, "R9");
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();

    // R10 mode 1 ignores the byte
    cur_req = "R10";
    pulse(0, 0, 0, 0, 1, 2'd1);
    ack_data = 8'h55;
    pulse(1, 1, 0, 0, 0, 0);
    expect_ev(1, 2, 0, 0, "R10");
    expect_ev(2, 0, 16'h0038, 0, "R10");
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();

    // R11 mode 2 table address
    cur_req = "R11";
    pulse(0, 0, 0, 0, 1, 2'd2);
    ireg = 8'h12; ack_data = 8'h35;
    pulse(1, 1, 0, 0, 0, 0);
    expect_ev(1, 2, 0, 0, "R11");
    expect_ev(2, 0, 16'h1234, 1, "R11");
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();

    // R12 code 3 ignored: still mode 2
    cur_req = "R12";
    pulse(0, 0, 0, 0, 1, 2'd3);
    ireg = 8'hAB; ack_data = 8'hFF;
    pulse(1, 1, 0, 0, 0, 0);
    expect_ev(1, 2, 0, 0, "R12");
    expect_ev(2, 0, 16'hABFE, 1, "R12");
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();
    int_n = 1;

    // R3 short low pulse on the maskable line is lost
    cur_req = "R3";
    pulse(1, 1, 0, 0, 0, 0);
    int_n = 0; tick(); int_n = 1;
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();
    chk(iff_o == 2'b11, "R3 nothing taken, iff kept", iff_o, 3);

    // R4 disable clears both and blocks
    cur_req = "R4";
    pulse(0, 0, 1, 0, 0, 0);
    chk(iff_o == 2'b00, "R4 disable clears both", iff_o, 0);
    int_n = 0;
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();
    int_n = 1;

    // R1/R7 non-maskable edge, no retrigger while held, return restores
    cur_req = "R1";
    pulse(1, 1, 0, 0, 0, 0);
    nmi_n = 0; tick();
    expect_ev(1, 0, 16'h0066, 0, "R1");
    pulse(1, 0, 0, 0, 0, 0);
    chk(iff_o == 2'b10, "R7 iff after non-maskable", iff_o, 2);
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();
    cur_req = "R7";
    pulse(0, 0, 0, 1, 0, 0);
    chk(iff_o == 2'b11, "R7 return restores IFF1", iff_o, 3);
    nmi_n = 1; tick();

    // R2 both pending: non-maskable first, maskable later
    cur_req = "R2";
    int_n = 0; nmi_n = 0; tick();
    expect_ev(1, 0, 16'h0066, 0, "R2");
    pulse(1, 0, 0, 0, 0, 0);
    pulse(1, 0, 0, 0, 0, 0);
    tick();
    pulse(0, 0, 0, 1, 0, 0);
    expect_ev(1, 2, 0, 0, "R2");
    expect_ev(2, 0, 16'hABFE, 1, "R2");
    pulse(1, 0, 0, 0, 0, 0);
    tick(); tick();
    int_n = 1; nmi_n = 1; tick();

    // R13 boundary during acknowledge ignored; deferred edge taken later
    cur_req = "R13";
    pulse(1, 1, 0, 0, 0, 0);
    int_n = 0;
    expect_ev(1, 2, 0, 0, "R13");
    expect_ev(2, 0, 16'hABFE, 1, "R13");
    expect_ev(4, 0, 16'h0066, 0, "R13");
    insn_end = 1; nmi_n = 0;
    tick();
    tick();
    insn_end = 0;
    tick();
    insn_end = 1;
    tick();
    insn_end = 0;
    int_n = 1; nmi_n = 1;
    tick(); tick(); tick();

    chk(exp_q.size() == 0, "R13 all expected events seen", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule